// File: doc/BRIEF.md
# Serial Flash Write-Protection Front End

This block sits behind the SPI slave of a serial NOR flash command decoder and decides whether each data-modifying instruction may proceed. For every instruction that ends with chip select rising, it receives one event carrying the opcode, the 24-bit address, the number of serial clocks counted while select was low and a lock value. Within one cycle it answers with a one-cycle grant or a one-cycle reject. Non-modifying instructions get no answer.

Acceptance depends on several kinds of state. The block holds the write-enable latch. It runs a power-up inhibit timer that starts from the power-on reset. It keeps one lock bit per 64 KB sector, selected by address bits 23:16. It also reads a hardware protect pin that freezes status-register writes. A separate completion pulse, tagged with the opcode of the instruction that just finished, clears the latch for the instructions that consume it. The block reports each such clear on a one-cycle pulse.

Top module: `flash_wr_guard`

## Requirements
- R1: While `por` is high, and in the cycle after it falls, `wel`, `grant`, `reject` and `wel_cleared` are 0 and `inhibit` is 1. Every sector lock is cleared by `por`.
- R2: After `por` falls, `inhibit` stays high for exactly INHIBIT_CYCLES clock cycles and then stays low. Every modifying instruction presented while it is high is rejected.
- R3: A command event with opcode 0x06 sets `wel` in the next cycle, whatever the timer state. If a clearing completion arrives in the same cycle, the set wins.
- R4: A modifying instruction presented while `wel` is 0 is rejected. A rejected instruction leaves `wel` unchanged.
- R5: A completion pulse whose opcode is one of 0x04, 0x01, 0xE5, 0x42, 0x02, 0xA2, 0xD2, 0x32, 0x12, 0x20, 0xD8 or 0xC7 clears `wel` in the next cycle. In that same cycle `wel_cleared` pulses, unless R3's set wins. A completion with any other opcode leaves both unchanged.
- R6: A program, erase, status write or OTP program (0x01, 0x42, 0x02, 0xA2, 0xD2, 0x32, 0x12, 0x20, 0xD8, 0xC7) is rejected when its clock count is not a multiple of 8. A lock write (0xE5) is exempt from this rule.
- R7: The modifying opcodes are 0x01, 0xE5, 0x42, 0x02, 0xA2, 0xD2, 0x32, 0x12, 0x20, 0xD8 and 0xC7. Each such command event produces exactly one of `grant` or `reject`, for one cycle, in the cycle after the event. Every other opcode produces neither.
- R8: A granted lock write (0xE5) loads `cmd_lock_set` into the lock bit of sector `cmd_addr[23:16]`.
- R9: A page or fast program (0x02, 0xA2, 0xD2, 0x32, 0x12) or a subsector or sector erase (0x20, 0xD8) whose sector lock is set is rejected. Unlocked sectors are unaffected.
- R10: Bulk erase (0xC7) is rejected while any sector lock is set.
- R11: A status write (0x01) is rejected while `hw_protect` is 1. Other instructions do not depend on `hw_protect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| hw_protect | input | 1 | Hardware protect pin; 1 freezes status writes |
| cmd_valid | input | 1 | One-cycle event at chip-select rising edge |
| cmd_op | input | 8 | Opcode of the finished command frame |
| cmd_addr | input | ADDR_W (24) | Address carried by the command |
| cmd_clks | input | CLK_CNT_W (16) | Serial clocks seen while select was low |
| cmd_lock_set | input | 1 | Value written by a lock write |
| done_valid | input | 1 | One-cycle completion pulse |
| done_op | input | 8 | Opcode of the completed instruction |
| grant | output | 1 | One-cycle accept of a modifying command |
| reject | output | 1 | One-cycle refusal of a modifying command |
| wel | output | 1 | Write-enable latch |
| inhibit | output | 1 | Power-up inhibit timer running |
| wel_cleared | output | 1 | One-cycle pulse when a completion clears the latch |

## Verification
On every cycle the checker confirms several rules. Grant and reject never coincide. A verdict only follows a command event. No grant follows an event presented during inhibit, with the latch clear, with a partial byte, or with a status write under the protect pin. It also checks that the latch sets after 0x06 and clears after a clearing completion, and that `inhibit` never returns once it has dropped. Only the bench's scenarios can show the following. The timer length is exact. Lock bits follow the addressed sector and are cleared again by reset. Bulk erase looks at every lock. The set-over-clear priority holds when both events land in the same cycle.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    localparam logic [7:0] OP_LATCH_SET   = 8'h06;
    localparam logic [7:0] OP_LATCH_DROP  = 8'h04;
    localparam logic [7:0] OP_STAT_WR     = 8'h01;
    localparam logic [7:0] OP_LOCK_WR     = 8'hE5;
    localparam logic [7:0] OP_OTP_PROG    = 8'h42;
    localparam logic [7:0] OP_PAGE_PROG   = 8'h02;
    localparam logic [7:0] OP_PROG_DUAL   = 8'hA2;
    localparam logic [7:0] OP_PROG_DUAL_X = 8'hD2;
    localparam logic [7:0] OP_PROG_QUAD   = 8'h32;
    localparam logic [7:0] OP_PROG_QUAD_X = 8'h12;
    localparam logic [7:0] OP_ERASE_SUB   = 8'h20;
    localparam logic [7:0] OP_ERASE_SECT  = 8'hD8;
    localparam logic [7:0] OP_ERASE_ALL   = 8'hC7;

    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'd0,
        VERDICT_GRANT  = 2'd1,
        VERDICT_REJECT = 2'd2
    } verdict_e;

    typedef struct packed {
        logic modifying;   // needs the latch and gets a verdict
        logic array_op;    // targets one sector, subject to its lock
        logic bulk;        // whole array, subject to every lock
        logic stat_wr;     // frozen by the protect pin
        logic lock_wr;     // updates a sector lock
        logic whole_bytes; // clock count must be a multiple of 8
    } op_class_t;

    function automatic op_class_t classify(input logic [7:0] op);
        op_class_t c;
        c = '0;
        case (op)
            OP_PAGE_PROG, OP_PROG_DUAL, OP_PROG_DUAL_X,
            OP_PROG_QUAD, OP_PROG_QUAD_X, OP_ERASE_SUB, OP_ERASE_SECT: begin
                c.modifying   = 1'b1;
                c.array_op    = 1'b1;
                c.whole_bytes = 1'b1;
            end
            OP_ERASE_ALL: begin
                c.modifying   = 1'b1;
                c.bulk        = 1'b1;
                c.whole_bytes = 1'b1;
            end
            OP_STAT_WR: begin
                c.modifying   = 1'b1;
                c.stat_wr     = 1'b1;
                c.whole_bytes = 1'b1;
            end
            OP_OTP_PROG: begin
                c.modifying   = 1'b1;
                c.whole_bytes = 1'b1;
            end
            OP_LOCK_WR: begin
                c.modifying = 1'b1;
                c.lock_wr   = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Completion of these opcodes consumes the write-enable latch.
    function automatic logic drops_latch(input logic [7:0] op);
        return classify(op).modifying || (op == OP_LATCH_DROP);
    endfunction

endpackage

// File: rtl/fwg_power_timer.sv
module fwg_power_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic por,
    output logic inhibit
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (por) begin
            remain_q <= CW'(CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign inhibit = (remain_q != '0);
endmodule

// File: rtl/fwg_lock_bank.sv
module fwg_lock_bank #(
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              por,
    input  logic              wr_en,
    input  logic [SECT_W-1:0] wr_sector,
    input  logic              wr_val,
    input  logic [SECT_W-1:0] rd_sector,
    output logic              rd_locked,
    output logic              any_locked
);
    localparam int NUM_SECT = 1 << SECT_W;

    logic [NUM_SECT-1:0] lock_vec;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        logic bit_q;
        always_ff @(posedge clk) begin
            if (por) begin
                bit_q <= 1'b0;
            end else if (wr_en && (wr_sector == SECT_W'(s))) begin
                bit_q <= wr_val;
            end
        end
        assign lock_vec[s] = bit_q;
    end

    assign rd_locked  = lock_vec[rd_sector];
    assign any_locked = |lock_vec;
endmodule

// File: rtl/fwg_wel_latch.sv
module fwg_wel_latch (
    input  logic clk,
    input  logic por,
    input  logic set_req,
    input  logic clr_req,
    output logic wel,
    output logic cleared
);
    always_ff @(posedge clk) begin
        if (por) begin
            wel     <= 1'b0;
            cleared <= 1'b0;
        end else begin
            if (set_req) begin
                wel <= 1'b1;
            end else if (clr_req) begin
                wel <= 1'b0;
            end
            cleared <= clr_req && !set_req;
        end
    end
endmodule

// File: rtl/fwg_verdict.sv
module fwg_verdict
    import fwg_pkg::*;
(
    input  op_class_t cls,
    input  logic      wel,
    input  logic      inhibit,
    input  logic      hw_protect,
    input  logic      partial_byte,
    input  logic      sector_locked,
    input  logic      any_locked,
    output verdict_e  verdict
);
    logic blocked;

    always_comb begin
        blocked = inhibit
               || !wel
               || (cls.whole_bytes && partial_byte)
               || (cls.stat_wr && hw_protect)
               || (cls.array_op && sector_locked)
               || (cls.bulk && any_locked);
        if (!cls.modifying) begin
            verdict = VERDICT_NONE;
        end else if (blocked) begin
            verdict = VERDICT_REJECT;
        end else begin
            verdict = VERDICT_GRANT;
        end
    end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
    import fwg_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int SECTOR_LSB     = 16,
    parameter int CLK_CNT_W      = 16,
    parameter int INHIBIT_CYCLES = 1000
) (
    input  logic                 clk,
    input  logic                 por,
    input  logic                 hw_protect,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [CLK_CNT_W-1:0] cmd_clks,
    input  logic                 cmd_lock_set,
    input  logic                 done_valid,
    input  logic [7:0]           done_op,
    output logic                 grant,
    output logic                 reject,
    output logic                 wel,
    output logic                 inhibit,
    output logic                 wel_cleared
);
    localparam int SECT_W = ADDR_W - SECTOR_LSB;

    op_class_t         cls;
    verdict_e          verdict;
    logic [SECT_W-1:0] sector;
    logic              sector_locked;
    logic              any_locked;
    logic              partial_byte;
    logic              lock_wr_en;
    logic              set_req;
    logic              clr_req;
    logic              addr_low_unused;

    assign cls             = classify(cmd_op);
    assign sector          = cmd_addr[ADDR_W-1:SECTOR_LSB];
    assign addr_low_unused = ^cmd_addr[SECTOR_LSB-1:0];
    assign partial_byte    = (cmd_clks % CLK_CNT_W'(8)) != '0;

    fwg_power_timer #(.CYCLES(INHIBIT_CYCLES)) u_timer (
        .clk     (clk),
        .por     (por),
        .inhibit (inhibit)
    );

    fwg_verdict u_verdict (
        .cls           (cls),
        .wel           (wel),
        .inhibit       (inhibit),
        .hw_protect    (hw_protect),
        .partial_byte  (partial_byte),
        .sector_locked (sector_locked),
        .any_locked    (any_locked),
        .verdict       (verdict)
    );

    assign lock_wr_en = cmd_valid && cls.lock_wr && (verdict == VERDICT_GRANT);

    fwg_lock_bank #(.SECT_W(SECT_W)) u_locks (
        .clk        (clk),
        .por        (por),
        .wr_en      (lock_wr_en),
        .wr_sector  (sector),
        .wr_val     (cmd_lock_set),
        .rd_sector  (sector),
        .rd_locked  (sector_locked),
        .any_locked (any_locked)
    );

    assign set_req = cmd_valid && (cmd_op == OP_LATCH_SET);
    assign clr_req = done_valid && drops_latch(done_op);

    fwg_wel_latch u_latch (
        .clk     (clk),
        .por     (por),
        .set_req (set_req),
        .clr_req (clr_req),
        .wel     (wel),
        .cleared (wel_cleared)
    );

    always_ff @(posedge clk) begin
        if (por) begin
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= cmd_valid && (verdict == VERDICT_GRANT);
            reject <= cmd_valid && (verdict == VERDICT_REJECT);
        end
    end
endmodule

// File: rtl/flash_wr_guard_chk.sv
module flash_wr_guard_chk
    import fwg_pkg::*;
#(
    parameter int CLK_CNT_W = 16
) (
    input logic                 clk,
    input logic                 por,
    input logic                 hw_protect,
    input logic                 cmd_valid,
    input logic [7:0]           cmd_op,
    input logic [CLK_CNT_W-1:0] cmd_clks,
    input logic                 done_valid,
    input logic [7:0]           done_op,
    input logic                 grant,
    input logic                 reject,
    input logic                 wel,
    input logic                 inhibit
);
    logic clr_evt;
    assign clr_evt = done_valid && (
        done_op == OP_LATCH_DROP || done_op == OP_STAT_WR || done_op == OP_LOCK_WR ||
        done_op == OP_OTP_PROG || done_op == OP_PAGE_PROG || done_op == OP_PROG_DUAL ||
        done_op == OP_PROG_DUAL_X || done_op == OP_PROG_QUAD || done_op == OP_PROG_QUAD_X ||
        done_op == OP_ERASE_SUB || done_op == OP_ERASE_SECT || done_op == OP_ERASE_ALL);

    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (por)
        !(grant && reject)); // R7
    AST_VERDICT_NEEDS_CMD: assert property (@(posedge clk) disable iff (por)
        (grant || reject) |-> $past(cmd_valid)); // R7
    AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (por)
        (cmd_valid && inhibit) |=> !grant); // R2
    AST_INHIBIT_STAYS_LOW: assert property (@(posedge clk) disable iff (por)
        !inhibit |=> !inhibit); // R2
    AST_NO_LATCH_NO_GRANT: assert property (@(posedge clk) disable iff (por)
        (cmd_valid && !wel) |=> !grant); // R4
    AST_LATCH_SET: assert property (@(posedge clk) disable iff (por)
        (cmd_valid && cmd_op == OP_LATCH_SET) |=> wel); // R3
    AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (por)
        (clr_evt && !(cmd_valid && cmd_op == OP_LATCH_SET)) |=> !wel); // R5
    AST_PARTIAL_BYTE: assert property (@(posedge clk) disable iff (por)
        (cmd_valid && cmd_clks[2:0] != 3'd0 && cmd_op != OP_LOCK_WR) |=> !grant); // R6
    AST_PIN_FREEZE: assert property (@(posedge clk) disable iff (por)
        (cmd_valid && cmd_op == OP_STAT_WR && hw_protect) |=> !grant); // R11
endmodule

bind flash_wr_guard flash_wr_guard_chk #(.CLK_CNT_W(CLK_CNT_W)) u_chk (
    .clk        (clk),
    .por        (por),
    .hw_protect (hw_protect),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_clks   (cmd_clks),
    .done_valid (done_valid),
    .done_op    (done_op),
    .grant      (grant),
    .reject     (reject),
    .wel        (wel),
    .inhibit    (inhibit)
);

// File: tb/flash_wr_guard_bench.sv
module flash_wr_guard_bench;
    import fwg_pkg::*;

    localparam int INH = 40;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        hw_protect = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [23:0] cmd_addr = 24'h0;
    logic [15:0] cmd_clks = 16'h0;
    logic        cmd_lock_set = 1'b0;
    logic        done_valid = 1'b0;
    logic [7:0]  done_op = 8'h00;
    logic        grant, reject, wel, inhibit, wel_cleared;

    always #4 clk = ~clk;

    flash_wr_guard #(.INHIBIT_CYCLES(INH)) u_flash_wr_guard (
        .clk(clk), .por(por), .hw_protect(hw_protect), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_clks(cmd_clks),
        .cmd_lock_set(cmd_lock_set), .done_valid(done_valid), .done_op(done_op),
        .grant(grant), .reject(reject), .wel(wel), .inhibit(inhibit),
        .wel_cleared(wel_cleared)
    );

    typedef struct {
        verdict_e v;
        string    tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected verdict per observed verdict
    always @(negedge clk) begin
        if (!por && (grant || reject)) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "unexpected verdict", {30'd0, grant, reject}, 0);
            end else begin
                exp_t e;
                int   act;
                e   = sb_q.pop_front();
                act = (grant && !reject) ? int'(VERDICT_GRANT)
                    : (reject && !grant) ? int'(VERDICT_REJECT) : 3;
                check(act == int'(e.v), e.tag, "verdict", act, int'(e.v));
            end
        end
    end

    task automatic send(input logic [7:0] op, input logic [23:0] addr, input int clks,
                        input logic lv, input verdict_e ex, input string tag);
        @(negedge clk);
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_addr     = addr;
        cmd_clks     = 16'(clks);
        cmd_lock_set = lv;
        if (ex != VERDICT_NONE) sb_q.push_back('{ex, tag});
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic complete(input logic [7:0] op, input bit with_set);
        @(negedge clk);
        done_valid = 1'b1;
        done_op    = op;
        if (with_set) begin
            cmd_valid = 1'b1;
            cmd_op    = OP_LATCH_SET;
        end
        @(negedge clk);
        done_valid = 1'b0;
        cmd_valid  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        por = 1'b1;
        repeat (3) @(negedge clk);
        check(wel == 1'b0 && grant == 1'b0 && reject == 1'b0 && wel_cleared == 1'b0,
              "R1", "outputs in reset", {28'd0, wel, grant, reject, wel_cleared}, 0);
        check(inhibit == 1'b1, "R1", "inhibit in reset", int'(inhibit), 1);
        por = 1'b0;
    endtask

    task automatic wait_timer();
        while (inhibit) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WATCHDOG", "timeout", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // R2: timer length
        do_reset();
        n = 0;
        while (inhibit) begin
            @(negedge clk);
            n++;
        end
        check(n == INH, "R2", "inhibit length", n, INH);
        repeat (5) @(negedge clk);
        check(inhibit == 1'b0, "R2", "inhibit stays low", int'(inhibit), 0);

        // R2/R3/R4: latch set during inhibit, modify still refused
        do_reset();
        send(OP_LATCH_SET, 24'h0, 8, 1'b0, VERDICT_NONE, "R3");
        check(wel == 1'b1, "R3", "latch set in inhibit", int'(wel), 1);
        send(OP_PAGE_PROG, 24'h010000, 32, 1'b0, VERDICT_REJECT, "R2");
        check(wel == 1'b1, "R4", "reject keeps latch", int'(wel), 1);
        wait_timer();

        // R5: write-disable completion
        complete(OP_LATCH_DROP, 1'b0);
        check(wel == 1'b0, "R5", "latch cleared by 0x04", int'(wel), 0);
        check(wel_cleared == 1'b1, "R5", "clear pulse", int'(wel_cleared), 1);
        send(OP_PAGE_PROG, 24'h010000, 32, 1'b0, VERDICT_REJECT, "R4");
        check(wel == 1'b0, "R4", "latch still clear", int'(wel), 0);

        // R5/R7: normal grant then program completion
        send(OP_LATCH_SET, 24'h0, 8, 1'b0, VERDICT_NONE, "R3");
        send(OP_PAGE_PROG, 24'h010000, 32, 1'b0, VERDICT_GRANT, "R7");
        complete(OP_PAGE_PROG, 1'b0);
        check(wel == 1'b0, "R5", "latch cleared by 0x02", int'(wel), 0);
        check(wel_cleared == 1'b1, "R5", "clear pulse after program", int'(wel_cleared), 1);

        // R5: non-clearing completion
        send(OP_LATCH_SET, 24'h0, 8, 1'b0, VERDICT_NONE, "R3");
        complete(8'h03, 1'b0);
        check(wel == 1'b1, "R5", "read completion keeps latch", int'(wel), 1);
        check(wel_cleared == 1'b0, "R5", "no pulse for read", int'(wel_cleared), 0);

        // R6/R8/R9/R10: byte rule and sector locks
        send(OP_PAGE_PROG, 24'h020000, 35, 1'b0, VERDICT_REJECT, "R6");
        send(OP_OTP_PROG, 24'h000000, 20, 1'b0, VERDICT_REJECT, "R6");
        send(OP_LOCK_WR, 24'h050000, 35, 1'b1, VERDICT_GRANT, "R6");
        send(OP_PAGE_PROG, 24'h051234, 40, 1'b0, VERDICT_REJECT, "R9");
        send(OP_PAGE_PROG, 24'h060000, 40, 1'b0, VERDICT_GRANT, "R9");
        send(OP_ERASE_SUB, 24'h05F000, 32, 1'b0, VERDICT_REJECT, "R9");
        send(OP_PROG_QUAD, 24'h05FFFF, 32, 1'b0, VERDICT_REJECT, "R9");
        send(OP_ERASE_ALL, 24'h000000, 8, 1'b0, VERDICT_REJECT, "R10");
        send(OP_LOCK_WR, 24'h05ABCD, 40, 1'b0, VERDICT_GRANT, "R8");
        send(OP_ERASE_SECT, 24'h050000, 32, 1'b0, VERDICT_GRANT, "R8");
        send(OP_ERASE_ALL, 24'h000000, 8, 1'b0, VERDICT_GRANT, "R10");
        send(OP_OTP_PROG, 24'h000000, 16, 1'b0, VERDICT_GRANT, "R7");

        // R11: protect pin freezes status writes only
        hw_protect = 1'b1;
        send(OP_STAT_WR, 24'h0, 16, 1'b0, VERDICT_REJECT, "R11");
        send(OP_ERASE_SECT, 24'h070000, 32, 1'b0, VERDICT_GRANT, "R11");
        hw_protect = 1'b0;
        send(OP_STAT_WR, 24'h0, 16, 1'b0, VERDICT_GRANT, "R11");

        // R7: non-modifying opcode yields no verdict
        send(8'h03, 24'h000100, 32, 1'b0, VERDICT_NONE, "R7");
        send(OP_LATCH_DROP, 24'h0, 8, 1'b0, VERDICT_NONE, "R7");

        // R3: set wins over same-cycle clear
        complete(OP_LATCH_DROP, 1'b0);
        check(wel == 1'b0, "R5", "cleared before priority case", int'(wel), 0);
        complete(OP_PAGE_PROG, 1'b1);
        check(wel == 1'b1, "R3", "set beats clear", int'(wel), 1);
        check(wel_cleared == 1'b0, "R3", "no pulse when set wins", int'(wel_cleared), 0);

        // R1: locks cleared by reset
        send(OP_LOCK_WR, 24'h090000, 16, 1'b1, VERDICT_GRANT, "R8");
        send(OP_ERASE_ALL, 24'h000000, 8, 1'b0, VERDICT_REJECT, "R10");
        do_reset();
        wait_timer();
        send(OP_LATCH_SET, 24'h0, 8, 1'b0, VERDICT_NONE, "R3");
        send(OP_ERASE_ALL, 24'h000000, 8, 1'b0, VERDICT_GRANT, "R1");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7", "pending verdicts", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule